// File: doc/BRIEF.md
# Linear-Hash Cache Way Predictor

This block keeps a small array of short hash tags, one for every entry of a set-associative data cache. A load offers its untranslated (linear) address. The block folds part of that address into a short hash and selects a set with the index bits. It then compares the hash against every stored tag of that set at once. It returns either the single way that should hold the line or a predicted miss. The data array can then read one way, with no need to wait for the physical address.

The fill logic maintains the array through two ports. A write stores the hash of a line's linear address in a chosen entry and makes that entry valid. Any other entry of the same set that already carries the same hash is dropped in the same step, so a set never holds two valid copies of one hash value. An invalidate port clears a single entry. Validating the guess against physical tags belongs to the surrounding cache and is not done here.

Top module: `way_predictor`

## Requirements
- R1: After reset every entry is invalid: every lookup reports a miss, and `rsp_valid` stays low until a lookup is made.
- R2: The set is linear address bits 11:6, and each lookup's set number is echoed on `rsp_set`.
- R3: The hash bit i (i = 0..7) is address bit 12+i XOR address bit 20+i. Two addresses with equal folded values hit the same entry, even when their raw bits 27:12 differ.
- R4: A lookup compares the hash with the stored tags of all eight ways of its set. On a hit, `rsp_hit` is 1 and `rsp_way` gives the way as an unsigned binary number 0..7. On a miss, `rsp_hit` is 0 and `rsp_way` is 0.
- R5: No lookup ever finds more than one matching valid entry.
- R6: A write stores the address hash in the given set and way and marks the entry valid. Every other valid entry in that set with the same hash becomes invalid.
- R7: The response to a lookup appears on the outputs exactly one clock edge after `lk_valid` is sampled high. `rsp_valid` is low after any edge at which `lk_valid` was low.
- R8: An invalidate clears only the addressed entry. Other ways of the same set keep their contents.
- R9: A lookup and a write to the same set on the same edge: the lookup is answered from the contents before the write.
- R10: A write and an invalidate to the same entry on the same edge leave the entry valid with the written hash.
- R11: Entries in one set never answer lookups to another set, even when the hash matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Linear address of the load |
| rsp_valid | output | 1 | Registered lookup response is present |
| rsp_hit | output | 1 | A matching valid entry was found |
| rsp_way | output | 3 | Predicted way (0 on miss) |
| rsp_set | output | 6 | Set of the answered lookup |
| wr_en | input | 1 | Write a tag |
| wr_set | input | 6 | Set to write |
| wr_way | input | 3 | Way to write |
| wr_addr | input | 48 | Linear address whose hash is stored |
| inv_en | input | 1 | Invalidate one entry |
| inv_set | input | 6 | Set to invalidate |
| inv_way | input | 3 | Way to invalidate |

## Verification
A lookup is answered one edge after it is sampled. A write or invalidate changes the array on the edge that samples it, so it is visible to a lookup sampled on the next edge. The bench drives every request on a falling edge and removes it on the following falling edge. It reads the response at that second falling edge, half a period after the edge that registered it. For the same-edge case, the write and the lookup share one falling edge, so the response shows the old contents. A second lookup one cycle later shows the new contents.

// File: rtl/way_predictor.sv
module way_predictor #(
  parameter int LA_W   = 48,
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_valid,
  input  logic [LA_W-1:0]           lk_addr,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [$clog2(WAYS)-1:0]   rsp_way,
  output logic [$clog2(SETS)-1:0]   rsp_set,
  input  logic                      wr_en,
  input  logic [$clog2(SETS)-1:0]   wr_set,
  input  logic [$clog2(WAYS)-1:0]   wr_way,
  input  logic [LA_W-1:0]           wr_addr,
  input  logic                      inv_en,
  input  logic [$clog2(SETS)-1:0]   inv_set,
  input  logic [$clog2(WAYS)-1:0]   inv_way
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int H_LO  = LINE_W + SET_W;

  function automatic logic [TAG_W-1:0] fold(input logic [LA_W-1:0] a);
    logic [TAG_W-1:0] h;
    for (int i = 0; i < TAG_W; i++) h[i] = a[H_LO+i] ^ a[H_LO+TAG_W+i];
    return h;
  endfunction

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  wire [SET_W-1:0] lk_set = lk_addr[H_LO-1:LINE_W];
  wire [TAG_W-1:0] lk_tag = fold(lk_addr);
  wire [TAG_W-1:0] wr_tag = fold(wr_addr);

  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] match_way;

  always_comb begin
    match_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      if (match[w]) match_way = match_way | WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_set   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|match);
      rsp_way   <= lk_valid ? match_way : '0;
      rsp_set   <= lk_valid ? lk_set : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (inv_en) vld_q[inv_set][inv_way] <= 1'b0;
      if (wr_en) begin
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) != wr_way && vld_q[wr_set][w] && tag_q[wr_set][w] == wr_tag)
            vld_q[wr_set][w] <= 1'b0;
        vld_q[wr_set][wr_way] <= 1'b1;
      end
    end
  end

  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(match));

  a_r7_reply_next: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  a_r4_miss_way_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_way == '0);

  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_set)][$past(wr_way)] &&
              tag_q[$past(wr_set)][$past(wr_way)] == $past(wr_tag));

  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(wr_en && wr_set == inv_set && wr_way == inv_way))
      |=> !vld_q[$past(inv_set)][$past(inv_way)]);
endmodule

// File: tb/way_predictor_test.sv
module way_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_way;
  logic [5:0]  rsp_set;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_set = '0;
  logic [2:0]  wr_way = '0;
  logic [47:0] wr_addr = '0;
  logic        inv_en = 1'b0;
  logic [5:0]  inv_set = '0;
  logic [2:0]  inv_way = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  way_predictor uut (.*);

  function automatic logic [47:0] mk(input int set, input int lo, input int hi);
    return (48'(hi & 255) << 20) | (48'(lo & 255) << 12) | (48'(set & 63) << 6) | 48'h15;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input string req, input logic [47:0] a, input bit hit, input int way);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 1);
    check({req, " hit"}, 32'(rsp_hit), 32'(hit));
    check({req, " way"}, 32'(rsp_way), hit ? 32'(way) : 0);
    check({req, " set"}, 32'(rsp_set), 32'(a[11:6]));
  endtask

  task automatic write(input int set, input int way, input logic [47:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_set = 6'(set); wr_way = 3'(way); wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic invalidate(input int set, input int way);
    @(negedge clk);
    inv_en = 1'b1; inv_set = 6'(set); inv_way = 3'(way);
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 idle valid", 32'(rsp_valid), 0);
    lookup("R1 empty a", mk(0, 0, 0), 0, 0);
    lookup("R1 empty b", mk(63, 8'hA5, 8'h3C), 0, 0);
    @(negedge clk);
    check("R7 idle after lookup", 32'(rsp_valid), 0);
  endtask

  task automatic t_basic;
    write(5, 3, mk(5, 8'h5A, 8'h00));
    lookup("R4 R6 hit way3", mk(5, 8'h5A, 8'h00), 1, 3);
    lookup("R3 folded alias", mk(5, 8'hFF, 8'hA5), 1, 3);
    lookup("R4 other hash miss", mk(5, 8'h5B, 8'h00), 0, 0);
    lookup("R2 R11 other set", mk(6, 8'h5A, 8'h00), 0, 0);
  endtask

  task automatic t_dup;
    write(5, 1, mk(5, 8'h11, 8'h00));
    write(5, 6, mk(5, 8'h00, 8'h5A));
    lookup("R6 R5 dup moves to way6", mk(5, 8'h5A, 8'h00), 1, 6);
    lookup("R6 unrelated way1 kept", mk(5, 8'h11, 8'h00), 1, 1);
  endtask

  task automatic t_inv;
    invalidate(5, 6);
    lookup("R8 cleared entry", mk(5, 8'h5A, 8'h00), 0, 0);
    lookup("R8 neighbour kept", mk(5, 8'h11, 8'h00), 1, 1);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    wr_en = 1'b1; wr_set = 6'd9; wr_way = 3'd2; wr_addr = mk(9, 8'h77, 8'h01);
    lk_valid = 1'b1; lk_addr = mk(9, 8'h77, 8'h01);
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    check("R9 old contents hit", 32'(rsp_hit), 0);
    check("R9 old contents valid", 32'(rsp_valid), 1);
    lookup("R9 new contents", mk(9, 8'h76, 8'h00), 1, 2);
  endtask

  task automatic t_wr_inv;
    @(negedge clk);
    wr_en = 1'b1; wr_set = 6'd12; wr_way = 3'd4; wr_addr = mk(12, 8'h33, 8'h00);
    inv_en = 1'b1; inv_set = 6'd12; inv_way = 3'd4;
    @(negedge clk);
    wr_en = 1'b0; inv_en = 1'b0;
    lookup("R10 write wins", mk(12, 8'h33, 8'h00), 1, 4);
  endtask

  task automatic t_full_set;
    for (int w = 0; w < 8; w++) write(20, w, mk(20, 8'h80 + w, 8'h00));
    for (int w = 7; w >= 0; w--) lookup("R4 full set", mk(20, 8'h80 + w, 8'h00), 1, w);
    lookup("R11 full set other index", mk(21, 8'h83, 8'h00), 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_dup();
    t_inv();
    t_same_edge();
    t_wr_inv();
    t_full_set();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule